// File: doc/BRIEF.md
# Fast Ethernet Receive Line Decoder

This block recovers MAC nibble data from a sampled three-level 100BASE-TX symbol stream. Each cycle of the recovered 125 MHz bit clock delivers one 2-bit line level. The level stream is turned into NRZI, then into NRZ, and then descrambled by an 11-stage LFSR. That LFSR locks itself to the stream while the link sends idle. Once the descrambler is locked, the plaintext is searched for the start-of-stream delimiter pair, which fixes the 5-bit code-group boundary. Each later code group is decoded to a nibble. The nibble is presented on MII-style receive outputs together with a data-valid flag and an error flag.

The output runs one code group behind the line. The delimiter pair comes out as two preamble nibbles, and each nibble is held for five bit clocks. A frame ends on the end-of-stream pair, on an idle code group, or on loss of descrambler lock. The descrambler drops lock and acquires again if no idle has been seen for a timeout that is counted in bit clocks.

Top module: `fe_rx_decoder`

## Requirements
- R1: Line coding. A change of the 2-bit level code (00 zero, 01 positive, 11 negative) between consecutive samples gives NRZI 1, and no change gives 0. A change of the NRZI bit between consecutive bits gives NRZ 1, and no change gives 0. Reset state: previous level 00, previous NRZI bit 0.
- R2: Descrambler lock. While unlocked, the LFSR shifts in the inverse of each received NRZ bit, which assumes an all-ones plaintext. The descrambler declares lock after LOCK_BITS (default 60) consecutive bits where the prediction s[10]^s[8] equals that inverse. While locked, the LFSR free-runs on s[10]^s[8], and plaintext = NRZ XOR s[10]^s[8].
- R3: If TIMEOUT_BITS consecutive locked bits pass with no idle seen, lock is dropped and acquisition restarts. Idle seen means IDLE_RUN (default 10) or more consecutive plaintext ones. The default of 90250 bits corresponds to 722 µs.
- R4: While unlocked, rx_dv_o stays 0 and any delimiter in the stream is ignored.
- R5: Outside a frame, the 10 most recent plaintext bits equal to J,K = 11000,10001 (earliest bit first) start a frame. The next bit clock shows rxd_o=0101 with rx_dv_o=1, and the following code-group slot shows 0101 again.
- R6: Data code groups follow the standard 4B/5B map (0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101, first-received bit is the leftmost). Each group is presented one slot later and held for 5 clocks.
- R7: T = 01101 followed by R = 00111 ends the frame. rx_dv_o falls in the slot after the last data nibble.
- R8: An idle code group (11111) inside a frame ends it without any error indication.
- R9: An undefined code group inside a frame yields one nibble with rx_dv_o=1, rx_er_o=1 and rxd_o=0000.
- R10: T followed by anything other than R yields one error nibble (rx_er_o=1, rxd_o=0000) directly after the last data nibble, then the frame ends.
- R11: During and after reset, rxd_o=0000, rx_dv_o=0 and rx_er_o=0.
- R12: Loss of lock inside a frame clears rx_dv_o on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mlt3_i | input | 2 | Sampled line level: 00 zero, 01 positive, 11 negative |
| rxd_o | output | 4 | Receive nibble |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error for the current nibble |

## Verification
A scrambled frame carrying every data nibble shows that line decoding, descrambling and the code table agree end to end. Frames ending on an undefined code, on an idle, and on a T that is not followed by R each separate one frame-end path from the others. A delimiter sent before lock shows that acquisition gates the framer. A long frame with no idle, followed by a change of scrambler seed, tells the timeout drop apart from a true re-acquisition.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  typedef struct packed {
    logic             v;
    logic             e;
    logic [NIB_W-1:0] d;
  } nib_t;

  localparam logic [2*SYM_W-1:0] JK_PAT = 10'b11000_10001;
  localparam logic [SYM_W-1:0]   C_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0]   C_T    = 5'b01101;
  localparam logic [SYM_W-1:0]   C_R    = 5'b00111;
  localparam nib_t NIB_NONE = '{v: 1'b0, e: 1'b0, d: 4'h0};
  localparam nib_t NIB_PRE  = '{v: 1'b1, e: 1'b0, d: 4'h5};
  localparam nib_t NIB_ERR  = '{v: 1'b1, e: 1'b1, d: 4'h0};

  function automatic nib_t dec_code(input logic [SYM_W-1:0] c);
    nib_t n;
    n = '{v: 1'b1, e: 1'b0, d: 4'h0};
    case (c)
      5'b11110: n.d = 4'h0;
      5'b01001: n.d = 4'h1;
      5'b10100: n.d = 4'h2;
      5'b10101: n.d = 4'h3;
      5'b01010: n.d = 4'h4;
      5'b01011: n.d = 4'h5;
      5'b01110: n.d = 4'h6;
      5'b01111: n.d = 4'h7;
      5'b10010: n.d = 4'h8;
      5'b10011: n.d = 4'h9;
      5'b10110: n.d = 4'hA;
      5'b10111: n.d = 4'hB;
      5'b11010: n.d = 4'hC;
      5'b11011: n.d = 4'hD;
      5'b11100: n.d = 4'hE;
      5'b11101: n.d = 4'hF;
      default:  n = NIB_ERR;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/fe_rx_line.sv
module fe_rx_line #(
  parameter int LVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             nrz_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             nrzi_q, nrzi_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= '0;
      nrzi_q   <= 1'b0;
      nrzi_d_q <= 1'b0;
      nrz_o    <= 1'b0;
    end else begin
      lvl_q    <= lvl_i;
      nrzi_q   <= (lvl_i != lvl_q);
      nrzi_d_q <= nrzi_q;
      nrz_o    <= nrzi_q ^ nrzi_d_q;
    end
  end
endmodule

// File: rtl/fe_rx_descram.sv
module fe_rx_descram #(
  parameter int LFSR_W       = 11,
  parameter int LFSR_TAP     = 9,
  parameter int LOCK_BITS    = 60,
  parameter int TIMEOUT_BITS = 90250,
  parameter int IDLE_RUN     = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nrz_i,
  output logic bit_o,
  output logic bit_v_o
);
  localparam int MC_W = $clog2(LOCK_BITS + 1);
  localparam int TC_W = $clog2(TIMEOUT_BITS + 1);
  localparam int RN_W = $clog2(IDLE_RUN + 1);

  logic [LFSR_W-1:0] s_q;
  logic              locked_q;
  logic [MC_W-1:0]   mcnt_q;
  logic [TC_W-1:0]   tcnt_q;
  logic [RN_W-1:0]   run_q;
  logic key, guess, plain, idle_seen, run_full;

  assign key       = s_q[LFSR_W-1] ^ s_q[LFSR_TAP-1];
  assign guess     = ~nrz_i;
  assign plain     = nrz_i ^ key;
  assign run_full  = (run_q == RN_W'(IDLE_RUN - 1));
  assign idle_seen = plain && run_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q      <= '0;
      locked_q <= 1'b0;
      mcnt_q   <= '0;
      tcnt_q   <= '0;
      run_q    <= '0;
      bit_o    <= 1'b0;
      bit_v_o  <= 1'b0;
    end else begin
      bit_o   <= plain;
      bit_v_o <= locked_q;
      if (!locked_q) begin
        // acquisition: assume idle plaintext of ones
        s_q    <= {s_q[LFSR_W-2:0], guess};
        run_q  <= '0;
        tcnt_q <= '0;
        if (key == guess) begin
          if (mcnt_q == MC_W'(LOCK_BITS - 1)) begin
            locked_q <= 1'b1;
            mcnt_q   <= '0;
          end else begin
            mcnt_q <= mcnt_q + 1'b1;
          end
        end else begin
          mcnt_q <= '0;
        end
      end else begin
        s_q   <= {s_q[LFSR_W-2:0], key};
        run_q <= !plain ? '0 : (run_full ? run_q : run_q + 1'b1);
        if (idle_seen) begin
          tcnt_q <= '0;
        end else if (tcnt_q == TC_W'(TIMEOUT_BITS - 1)) begin
          tcnt_q   <= '0;
          locked_q <= 1'b0;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end

  p_lock_after_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(mcnt_q) == MC_W'(LOCK_BITS - 1));

  p_drop_on_timeout_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> $past(tcnt_q) == TC_W'(TIMEOUT_BITS - 1));

  p_counters_idle_unlocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && $past(!locked_q)) |-> (tcnt_q == '0 && run_q == '0));
endmodule

// File: rtl/fe_rx_align.sv
module fe_rx_align
  import fe_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_v_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             rx_er_o
);
  localparam int WIN_W = 2 * SYM_W;
  localparam int PH_W  = $clog2(SYM_W);

  logic [WIN_W-1:0] win_q, win_n;
  logic [PH_W-1:0]  phase_q;
  logic             in_frame_q, saw_t_q;
  nib_t             held_q, out_q;
  logic [SYM_W-1:0] code;
  logic             start, bound;

  assign win_n = {win_q[WIN_W-2:0], bit_i};
  assign code  = win_n[SYM_W-1:0];
  assign start = bit_v_i && !in_frame_q && (win_n == JK_PAT);
  assign bound = bit_v_i && !start && (phase_q == PH_W'(SYM_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q      <= '0;
      phase_q    <= '0;
      in_frame_q <= 1'b0;
      saw_t_q    <= 1'b0;
      held_q     <= NIB_NONE;
      out_q      <= NIB_NONE;
    end else if (!bit_v_i) begin
      win_q      <= '0;
      phase_q    <= '0;
      in_frame_q <= 1'b0;
      saw_t_q    <= 1'b0;
      held_q     <= NIB_NONE;
      out_q      <= NIB_NONE;
    end else begin
      win_q <= win_n;
      if (start) begin
        in_frame_q <= 1'b1;
        saw_t_q    <= 1'b0;
        phase_q    <= '0;
        out_q      <= NIB_PRE;   // J slot
        held_q     <= NIB_PRE;   // K slot
      end else if (bound) begin
        phase_q <= '0;
        out_q   <= held_q;
        held_q  <= NIB_NONE;
        if (in_frame_q) begin
          if (saw_t_q) begin
            saw_t_q    <= 1'b0;
            in_frame_q <= 1'b0;
            if (code != C_R) out_q <= NIB_ERR;
          end else if (code == C_IDLE) begin
            in_frame_q <= 1'b0;
          end else if (code == C_T) begin
            saw_t_q <= 1'b1;
          end else begin
            held_q <= dec_code(code);
          end
        end
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign rxd_o   = out_q.d;
  assign rx_dv_o = out_q.v;
  assign rx_er_o = out_q.e;

  p_unlock_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_v_i |=> !rx_dv_o);

  p_preamble_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (rx_dv_o && !rx_er_o && rxd_o == 4'b0101));

  p_err_has_dv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_er_o |-> rx_dv_o);

  p_hold_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_v_i && !start && !bound) |=> $stable(out_q));
endmodule

// File: rtl/fe_rx_decoder.sv
module fe_rx_decoder
  import fe_rx_pkg::*;
#(
  parameter int LVL_W        = 2,
  parameter int LFSR_W       = 11,
  parameter int LFSR_TAP     = 9,
  parameter int LOCK_BITS    = 60,
  parameter int TIMEOUT_BITS = 90250,
  parameter int IDLE_RUN     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] mlt3_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             rx_er_o
);
  logic nrz, pbit, pbit_v;

  fe_rx_line #(.LVL_W(LVL_W)) u_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (mlt3_i),
    .nrz_o (nrz)
  );

  fe_rx_descram #(
    .LFSR_W      (LFSR_W),
    .LFSR_TAP    (LFSR_TAP),
    .LOCK_BITS   (LOCK_BITS),
    .TIMEOUT_BITS(TIMEOUT_BITS),
    .IDLE_RUN    (IDLE_RUN)
  ) u_descram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nrz_i  (nrz),
    .bit_o  (pbit),
    .bit_v_o(pbit_v)
  );

  fe_rx_align u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (pbit),
    .bit_v_i(pbit_v),
    .rxd_o  (rxd_o),
    .rx_dv_o(rx_dv_o),
    .rx_er_o(rx_er_o)
  );
endmodule

// File: tb/fe_rx_decoder_tb_top.sv
module fe_rx_decoder_tb_top;
  localparam time CLK_PERIOD = 8ns;
  localparam int  LOCK_BITS  = 60;
  localparam int  TMO_BITS   = 600;
  localparam int  IDLE_RUN   = 10;
  localparam int  WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mlt3 = 2'b00;
  logic [3:0] rxd;
  logic       rx_dv, rx_er;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fe_rx_decoder #(
    .LOCK_BITS   (LOCK_BITS),
    .TIMEOUT_BITS(TMO_BITS),
    .IDLE_RUN    (IDLE_RUN)
  ) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .mlt3_i (mlt3),
    .rxd_o  (rxd),
    .rx_dv_o(rx_dv),
    .rx_er_o(rx_er)
  );

  int enc5 [16] = '{'b11110, 'b01001, 'b10100, 'b10101, 'b01010, 'b01011, 'b01110, 'b01111,
                    'b10010, 'b10011, 'b10110, 'b10111, 'b11010, 'b11011, 'b11100, 'b11101};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- transmitter ----------------
  int tx_s = 'h5A5;
  int tx_nrzi = 0;
  int tx_idx = 0;

  task automatic send_bit(input int b);
    int key;
    key   = ((tx_s >> 10) ^ (tx_s >> 8)) & 1;
    tx_s  = ((tx_s << 1) | key) & 'h7FF;
    tx_nrzi ^= (b ^ key);
    if (tx_nrzi != 0) tx_idx = (tx_idx + 1) % 4;
    @(negedge clk);
    case (tx_idx)
      1: mlt3 = 2'b01;
      3: mlt3 = 2'b11;
      default: mlt3 = 2'b00;
    endcase
  endtask

  task automatic send_code(input int c);
    for (int i = 4; i >= 0; i--) send_bit((c >> i) & 1);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1);
  endtask

  // ---------------- behavioural reference ----------------
  int m_plvl, m_pnrzi, m_s, m_lock, m_mc, m_tc, m_run;
  int m_win, m_ph, m_inf, m_st, m_held, m_out;   // nibble word: v<<5 | e<<4 | d
  int nq[$];
  int bq[$];

  function automatic int m_dec(input int c);
    for (int i = 0; i < 16; i++) if (enc5[i] == c) return 32 | i;
    return 48;
  endfunction

  task automatic m_reset();
    m_plvl = 0; m_pnrzi = 0; m_s = 0; m_lock = 0; m_mc = 0; m_tc = 0; m_run = 0;
    m_win = 0; m_ph = 0; m_inf = 0; m_st = 0; m_held = 0; m_out = 0;
    nq = '{0, 0};
    bq = '{0};
  endtask

  task automatic m_step(input int lvl);
    int nrzi, x, key, pb, v, y, code;
    nrzi = (lvl != m_plvl); m_plvl = lvl;
    nq.push_back(nrzi ^ m_pnrzi); m_pnrzi = nrzi;
    x = nq.pop_front();
    key = ((m_s >> 10) ^ (m_s >> 8)) & 1;
    pb = x ^ key;
    v = m_lock;
    if (m_lock == 0) begin
      m_run = 0; m_tc = 0;
      if ((1 - x) == key) begin
        m_mc++;
        if (m_mc == LOCK_BITS) begin m_lock = 1; m_mc = 0; end
      end else m_mc = 0;
      m_s = ((m_s << 1) | (1 - x)) & 'h7FF;
    end else begin
      m_s = ((m_s << 1) | key) & 'h7FF;
      m_run = pb ? m_run + 1 : 0;
      if (m_run >= IDLE_RUN) m_tc = 0;
      else begin
        m_tc++;
        if (m_tc == TMO_BITS) begin m_lock = 0; m_tc = 0; end
      end
    end
    bq.push_back(v * 2 + pb);
    y = bq.pop_front();
    if ((y & 2) == 0) begin
      m_win = 0; m_ph = 0; m_inf = 0; m_st = 0; m_held = 0; m_out = 0;
    end else begin
      m_win = ((m_win << 1) | (y & 1)) & 'h3FF;
      code = m_win & 'h1F;
      if (m_inf == 0 && m_win == 'b1100010001) begin
        m_inf = 1; m_st = 0; m_ph = 0; m_out = 'h25; m_held = 'h25;
      end else if (m_ph == 4) begin
        m_ph = 0; m_out = m_held; m_held = 0;
        if (m_inf != 0) begin
          if (m_st != 0) begin
            m_st = 0; m_inf = 0;
            if (code != 'b00111) m_out = 48;
          end else if (code == 'b11111) m_inf = 0;
          else if (code == 'b01101) m_st = 1;
          else m_held = m_dec(code);
        end
      end else m_ph++;
    end
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step(int'(mlt3));
  end

  // per-clock comparison against the reference (R6 timing, R9 flags, R12 drop)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int act;
      act = {26'd0, rx_dv, rx_er, rxd};
      chk(act == m_out, "R6 per-clock model compare {dv,er,rxd}", act, m_out);
    end
  end

  // nibble capture: one sample per 5-clock slot while valid
  int cap[$];
  int cap_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n || !rx_dv) cap_cnt = 0;
    else begin
      if (cap_cnt % 5 == 0) cap.push_back({27'd0, rx_er, rxd});
      cap_cnt++;
    end
  end

  task automatic cmp_caps(input string tag, input int exp[$]);
    chk(cap.size() == exp.size(), {tag, " nibble count"}, cap.size(), exp.size());
    for (int i = 0; i < exp.size() && i < cap.size(); i++)
      chk(cap[i] == exp[i], {tag, " nibble"}, cap[i], exp[i]);
    cap.delete();
  endtask

  task automatic send_jk();
    send_code('b11000);
    send_code('b10001);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int exp[$];
    repeat (3) @(negedge clk);
    chk({rx_dv, rx_er, rxd} == 6'd0, "R11 outputs in reset", {rx_dv, rx_er, rxd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rx_dv, rx_er, rxd} == 6'd0, "R11 outputs after reset", {rx_dv, rx_er, rxd}, 0);

    // R4: delimiter before lock is ignored
    send_idle(20);
    send_jk();
    send_code(enc5[1]); send_code(enc5[2]); send_code(enc5[3]);
    send_code('b01101); send_code('b00111);
    send_idle(8);
    exp = {};
    cmp_caps("R4 no frame before lock", exp);

    // R1 R2 R5 R6 R7: full frame after lock
    send_idle(150);
    send_jk();
    for (int i = 0; i < 3; i++) send_code(enc5[5]);
    send_code(enc5[13]);
    for (int i = 0; i < 16; i++) send_code(enc5[i]);
    send_code('b01101); send_code('b00111);
    send_idle(40);
    exp = {5, 5, 5, 5, 5, 13};
    for (int i = 0; i < 16; i++) exp.push_back(i);
    cmp_caps("R1 R2 R5 R6 R7 frame", exp);
    chk(rx_dv == 1'b0, "R7 dv low after T/R", rx_dv, 0);

    // R9: undefined code group
    send_jk();
    send_code(enc5[1]); send_code(enc5[2]); send_code('b00000); send_code(enc5[3]);
    send_code('b01101); send_code('b00111);
    send_idle(40);
    exp = {5, 5, 1, 2, 16, 3};
    cmp_caps("R9 undefined code", exp);

    // R8: idle ends the frame
    send_jk();
    send_code(enc5[7]); send_code(enc5[8]);
    send_idle(40);
    exp = {5, 5, 7, 8};
    cmp_caps("R8 idle end", exp);
    chk(rx_er == 1'b0, "R8 no error after idle end", rx_er, 0);

    // R10: T not followed by R
    send_jk();
    send_code(enc5[9]); send_code('b01101); send_code(enc5[4]);
    send_idle(40);
    exp = {5, 5, 9, 16};
    cmp_caps("R10 T without R", exp);

    // R3 R12: no idle for longer than the timeout
    send_jk();
    for (int i = 0; i < 150; i++) send_code(enc5[i % 16]);
    repeat (4) @(negedge clk);
    chk(rx_dv == 1'b0, "R3 dv low after timeout", rx_dv, 0);
    chk(cap.size() >= 100 && cap.size() < 152, "R12 frame cut by lock loss", cap.size(), 120);
    cap.delete();

    // R2: re-acquire on a new scrambler seed
    tx_s = 'h3C1;
    send_idle(200);
    send_jk();
    send_code(enc5[5]); send_code(enc5[13]); send_code(enc5[12]);
    send_code('b01101); send_code('b00111);
    send_idle(40);
    exp = {5, 5, 5, 13, 12};
    cmp_caps("R2 re-acquired frame", exp);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule